// File: doc/BRIEF.md
# Synchronous Flash Read-Path Controller

This block is the read-side control logic of a synchronous NOR flash die. It watches the chip-select, output-enable, write-enable and address-valid strobes on each clock edge. It decodes command writes that arrive on an 8-bit command input. It tracks whether reads return array words or register words. It also holds the 16-bit read configuration word, which selects between plain asynchronous reads and clocked burst reads.

In asynchronous mode, the address sent to the array simply follows the address pins. In burst mode, the controller captures a start address once per address-valid pulse. It then counts the programmed initial latency while driving a wait indication. After that it steps the array address once per clock, either wrapping inside an aligned 4, 8 or 16 word window or counting straight up. When a read access ends, the controller drops into a low-activity power-saving state and stays there until the chip is selected again.

Top module: `flash_rdctl`

## Requirements
- R1: After reset, `cfg_o` reads 16'hFFFF, `burst_on` is 0, `arr_sel` is 1 (array mode), `aps` is 0 and `dvalid` is 0.
- R2: A configuration write takes two command writes, 8'h60 followed by 8'h03. On the second write, `addr[15:0]` is copied into `cfg_o`. `burst_on` equals the inverse of `cfg_o[15]`.
- R3: The configuration confirm is ignored, and `cfg_o` keeps its value, if any address bit above bit 15 is 1 or if any of the reserved bits 14, 5 and 4 is 1.
- R4: While `burst_on` is 0, `mem_addr` equals `addr` combinationally.
- R5: In burst mode, the start address is taken on the first rising clock edge with `ce_n` and `adv_n` both low. Further edges while `adv_n` stays low do not re-capture it.
- R6: The latency code is held in `cfg_o[13:11]` and has the value LC. After the capturing edge, `dvalid` stays 0 and the wait state stays asserted for LC cycles. `dvalid` then rises, and the first word address equals the start address.
- R7: Bits 2:0 of the configuration select the burst length: 1 means 4 words, 2 means 8 words and 3 means 16 words. When `cfg_o[3]` is 0 and one of these lengths is selected, each valid cycle with `oe_n` low advances `mem_addr` by one modulo the length, and the aligned upper bits stay unchanged.
- R8: When `cfg_o[3]` is 1, or when the length code is any other value (continuous), the burst address counts up linearly modulo 2^AW across every boundary.
- R9: A configuration write opens array access for the first burst without a read-array command (8'hFF). Once that access ends, `arr_sel` falls to 0 until 8'hFF is written.
- R10: After the status command 8'h70, `arr_sel` is 0, and a burst read never raises `dvalid`.
- R11: `aps` rises on the first edge with `ce_n` high that follows an edge where `ce_n` and `oe_n` were both low. It clears on the first edge with `ce_n` low.
- R12: `cfg_o[10]` sets the wait polarity. When it is 1, `wait_o` is high while the block is waiting. When it is 0, `wait_o` is low while the block is waiting. Outside the wait state `wait_o` takes the opposite level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| adv_n | input | 1 | Address valid, active low |
| addr | input | AW | Address pins |
| cmd | input | 8 | Command byte for writes |
| mem_addr | output | AW | Address sent to the array |
| arr_sel | output | 1 | 1: array data, 0: register data |
| burst_on | output | 1 | Burst mode configured |
| dvalid | output | 1 | Burst word valid this cycle |
| wait_o | output | 1 | Wait indication, polarity set by configuration |
| aps | output | 1 | Automatic power-saving state |
| cfg_o | output | 16 | Configuration word |

## Verification
The bench builds the block with AW = 18 and WRAP_EN = 1. This is wide enough to exercise the high-address rejection and a burst that counts through the top of the address space. It sweeps every wrapping length and the continuous code, both wrap settings and several start offsets, including offsets at the end of a window and at the top of memory. The latency is rotated across the bursts, and a separate run covers all eight latency codes. Expected addresses are computed arithmetically from the start address, the length and the wrap setting.

// File: rtl/flash_rdctl_pkg.sv
package flash_rdctl_pkg;
   localparam int CFG_W = 16;
   localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
   localparam logic [7:0] CMD_RD_STAT  = 8'h70;
   localparam logic [7:0] CMD_CFG_SET  = 8'h60;
   localparam logic [7:0] CMD_CFG_CONF = 8'h03;
   // configuration field positions
   localparam int F_MODE   = 15;
   localparam int F_RSV_HI = 14;
   localparam int F_LAT_LO = 11;
   localparam int F_WPOL   = 10;
   localparam int F_RSV_A  = 5;
   localparam int F_RSV_B  = 4;
   localparam int F_WRAP_N = 3;
   typedef enum logic {MD_ARRAY, MD_REG} rd_mode_e;
   typedef enum logic {ST_IDLE, ST_CFG} cmd_st_e;
endpackage

// File: rtl/frc_aps.sv
module frc_aps (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   output logic aps,
   output logic rd_end
);
   logic rd_prev;

   assign rd_end = ce_n & rd_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_prev <= 1'b0;
         aps     <= 1'b0;
      end else begin
         rd_prev <= ~ce_n & ~oe_n;
         if (!ce_n)       aps <= 1'b0;
         else if (rd_prev) aps <= 1'b1;
      end
   end

   AST_APS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_n |=> !aps); // R11
endmodule

// File: rtl/frc_cmd_ctl.sv
module frc_cmd_ctl
   import flash_rdctl_pkg::*;
#(
   parameter int AW = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             we_n,
   input  logic [7:0]       cmd,
   input  logic [AW-1:0]    addr,
   input  logic             rd_end,
   output logic [CFG_W-1:0] cfg_q,
   output logic             arr_sel,
   output logic             burst_en
);
   localparam int HI_W = AW - CFG_W;

   rd_mode_e mode;
   cmd_st_e  st;
   logic     skip;
   logic     wr;
   logic     addr_ok;

   assign wr       = ~ce_n & ~we_n;
   assign addr_ok  = (addr[AW-1:CFG_W] == {HI_W{1'b0}}) & ~addr[F_RSV_HI]
                   & ~addr[F_RSV_A] & ~addr[F_RSV_B];
   assign burst_en = ~cfg_q[F_MODE];
   assign arr_sel  = (mode == MD_ARRAY) | (skip & burst_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '1;
         mode  <= MD_ARRAY;
         st    <= ST_IDLE;
         skip  <= 1'b0;
      end else if (wr) begin
         skip <= 1'b0;
         if (st == ST_IDLE) begin
            if (cmd == CMD_CFG_SET)       st   <= ST_CFG;
            else if (cmd == CMD_RD_ARRAY) mode <= MD_ARRAY;
            else if (cmd == CMD_RD_STAT)  mode <= MD_REG;
         end else begin
            st <= ST_IDLE;
            if (cmd == CMD_CFG_CONF && addr_ok) begin
               cfg_q <= addr[CFG_W-1:0];
               mode  <= MD_REG;
               skip  <= 1'b1;
            end
         end
      end else if (rd_end) begin
         skip <= 1'b0;
      end
   end

   AST_CFG_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q != $past(cfg_q)) |-> (!cfg_q[F_RSV_HI] && !cfg_q[F_RSV_A] && !cfg_q[F_RSV_B])); // R3
   AST_SKIP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(skip) |-> $past(wr && st == ST_CFG)); // R9
endmodule

// File: rtl/frc_burst_gen.sv
module frc_burst_gen #(
   parameter int AW      = 20,
   parameter int LAT_W   = 3,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             oe_n,
   input  logic             adv_n,
   input  logic [AW-1:0]    addr,
   input  logic             burst_en,
   input  logic             arr_sel,
   input  logic [LAT_W-1:0] lat_code,
   input  logic             wrap_n,
   input  logic [2:0]       len_code,
   output logic [AW-1:0]    mem_addr,
   output logic             dvalid,
   output logic             busy
);
   logic             active;
   logic             adv_seen;
   logic [LAT_W-1:0] lat;
   logic [AW-1:0]    cur;
   logic [AW-1:0]    nxt;
   logic [AW-1:0]    mask;
   logic             lat_ev;
   logic             step;

   assign lat_ev   = burst_en & ~ce_n & ~adv_n & ~adv_seen;
   assign dvalid   = active & (lat == '0) & arr_sel;
   assign busy     = active & (lat != '0);
   assign step     = dvalid & ~oe_n & ~ce_n & burst_en & ~lat_ev;
   assign mem_addr = burst_en ? cur : addr;

   always_comb begin
      case (len_code)
         3'd1:    mask = AW'(3);
         3'd2:    mask = AW'(7);
         3'd3:    mask = AW'(15);
         default: mask = '0;
      endcase
   end

   generate
      if (WRAP_EN) begin : g_wrap
         logic wrap_on;
         assign wrap_on = ~wrap_n & (mask != '0);
         assign nxt = wrap_on ? ((cur & ~mask) | ((cur + AW'(1)) & mask))
                              : cur + AW'(1);
         AST_WRAP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
            (step && wrap_on) |=> (((cur ^ $past(cur)) & ~$past(mask)) == '0)); // R7
      end else begin : g_lin
         assign nxt = cur + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adv_seen <= 1'b0;
         active   <= 1'b0;
         lat      <= '0;
         cur      <= '0;
      end else begin
         adv_seen <= ~adv_n & ~ce_n;
         if (ce_n || !burst_en) begin
            active <= 1'b0;
            lat    <= '0;
         end else if (lat_ev) begin
            active <= 1'b1;
            cur    <= addr;
            lat    <= lat_code;
         end else if (active) begin
            if (lat != '0)  lat <= lat - 1'b1;
            else if (step)  cur <= nxt;
         end
      end
   end

   AST_LATCH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && burst_en && !adv_n && adv_seen && active && lat != '0) |=> $stable(cur)); // R5
   AST_LAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (active && lat != '0 && !ce_n && burst_en && !lat_ev) |=> (lat == $past(lat) - 1'b1)); // R6
endmodule

// File: rtl/flash_rdctl.sv
module flash_rdctl
   import flash_rdctl_pkg::*;
#(
   parameter int AW      = 20,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic          adv_n,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    cmd,
   output logic [AW-1:0] mem_addr,
   output logic          arr_sel,
   output logic          burst_on,
   output logic          dvalid,
   output logic          wait_o,
   output logic          aps,
   output logic [15:0]   cfg_o
);
   localparam int LAT_W = 3;

   generate
      if (AW < CFG_W + 1) begin : g_bad_aw
         $error("flash_rdctl: AW must exceed the configuration width");
      end
   endgenerate

   logic rd_end;
   logic busy;

   frc_aps u_aps (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
      .aps(aps), .rd_end(rd_end)
   );

   frc_cmd_ctl #(.AW(AW)) u_cmd (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cmd(cmd),
      .addr(addr), .rd_end(rd_end), .cfg_q(cfg_o), .arr_sel(arr_sel),
      .burst_en(burst_on)
   );

   frc_burst_gen #(.AW(AW), .LAT_W(LAT_W), .WRAP_EN(WRAP_EN)) u_burst (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .adv_n(adv_n),
      .addr(addr), .burst_en(burst_on), .arr_sel(arr_sel),
      .lat_code(cfg_o[F_LAT_LO +: LAT_W]), .wrap_n(cfg_o[F_WRAP_N]),
      .len_code(cfg_o[2:0]), .mem_addr(mem_addr), .dvalid(dvalid), .busy(busy)
   );

   assign wait_o = cfg_o[F_WPOL] ? busy : ~busy;

   AST_WAIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n && cfg_o[F_WPOL]) |=> (!wait_o || !ce_n || !cfg_o[F_WPOL])); // R12
endmodule

// File: tb/tb_flash_rdctl.sv
module tb_flash_rdctl;
   localparam int CLK_PERIOD = 10;
   localparam int BAW = 18;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, adv_n = 1'b1;
   logic [BAW-1:0] addr = '0;
   logic [7:0] cmd = 8'h00;
   logic [BAW-1:0] mem_addr;
   logic arr_sel, burst_on, dvalid, wait_o, aps;
   logic [15:0] cfg_o;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_rdctl #(.AW(BAW), .WRAP_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .adv_n(adv_n), .addr(addr), .cmd(cmd), .mem_addr(mem_addr),
      .arr_sel(arr_sel), .burst_on(burst_on), .dvalid(dvalid),
      .wait_o(wait_o), .aps(aps), .cfg_o(cfg_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] mk_cfg(input int lc, input bit pol, input bit bw, input logic [2:0] bl);
      logic [2:0] l3 = 3'(lc);
      return {1'b0, 1'b0, l3, pol, 4'b0000, 2'b00, bw, bl};
   endfunction

   function automatic logic [BAW-1:0] seq(input logic [BAW-1:0] s, input logic [2:0] bl,
                                          input bit bw, input int j);
      int len;
      logic [BAW-1:0] m;
      if (!bw && bl >= 3'd1 && bl <= 3'd3) begin
         len = 4 << (bl - 1);
         m = BAW'(len - 1);
         return (s & ~m) | ((s + BAW'(j)) & m);
      end
      return s + BAW'(j);
   endfunction

   task automatic wr_cmd(input logic [7:0] c, input logic [BAW-1:0] a);
      ce_n = 1'b0; we_n = 1'b0; cmd = c; addr = a;
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; cmd = 8'h00; addr = '0;
   endtask

   task automatic set_cfg(input logic [BAW-1:0] a);
      wr_cmd(8'h60, '0);
      wr_cmd(8'h03, a);
   endtask

   task automatic do_burst(input logic [BAW-1:0] s, input int lc, input int nw, input bit pol,
                           input logic [2:0] bl, input bit bw, input bit want, input bit hold);
      string tg;
      tg = (!bw && bl >= 3'd1 && bl <= 3'd3) ? "R7" : "R8";
      ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = s;
      @(negedge clk);
      if (hold) addr = s ^ BAW'('h155);
      else begin adv_n = 1'b1; addr = s ^ BAW'('h2AA); end
      for (int k = 0; k < lc; k++) begin
         chk("R6 wait level", 32'(wait_o), 32'(pol));
         chk("R6 no data in latency", 32'(dvalid), 32'(0));
         @(negedge clk); adv_n = 1'b1;
      end
      if (want) begin
         for (int j = 0; j < nw; j++) begin
            chk("R6 data valid", 32'(dvalid), 32'(1));
            chk("R12 wait released", 32'(wait_o), 32'(!pol));
            if (hold && j == 0) chk("R5 first capture kept", 32'(mem_addr), 32'(s));
            else chk(tg, 32'(mem_addr), 32'(seq(s, bl, bw, j)));
            @(negedge clk); adv_n = 1'b1;
         end
      end else begin
         for (int j = 0; j < nw; j++) begin
            chk("R10 no register burst", 32'(dvalid), 32'(0));
            @(negedge clk);
         end
      end
      ce_n = 1'b1; oe_n = 1'b1; adv_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [2:0] bls [4] = '{3'd1, 3'd2, 3'd3, 3'd7};
      logic [BAW-1:0] sts [5] = '{18'h00000, 18'h00003, 18'h0012D, 18'h0ABCF, 18'h3FFFE};
      int idx = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 cfg", 32'(cfg_o), 32'hFFFF);
      chk("R1 burst_on", 32'(burst_on), 0);
      chk("R1 arr_sel", 32'(arr_sel), 1);
      chk("R1 aps", 32'(aps), 0);
      chk("R1 dvalid", 32'(dvalid), 0);
      // R4
      addr = 18'h1234A; #1;
      chk("R4 async follow", 32'(mem_addr), 32'h1234A);
      addr = 18'h2F00F; #1;
      chk("R4 async follow", 32'(mem_addr), 32'h2F00F);
      addr = '0;
      // R3 rejections
      set_cfg(18'h10000 | BAW'(mk_cfg(2, 1, 0, 1)));
      chk("R3 high addr bit", 32'(cfg_o), 32'hFFFF);
      set_cfg(18'h04000 | BAW'(mk_cfg(2, 1, 0, 1)));
      chk("R3 reserved bit 14", 32'(cfg_o), 32'hFFFF);
      set_cfg(18'h00020 | BAW'(mk_cfg(2, 1, 0, 1)));
      chk("R3 reserved bit 5", 32'(cfg_o), 32'hFFFF);
      set_cfg(18'h00010 | BAW'(mk_cfg(2, 1, 0, 1)));
      chk("R3 reserved bit 4", 32'(cfg_o), 32'hFFFF);
      chk("R3 still async", 32'(burst_on), 0);
      // R2 + R9
      set_cfg(BAW'(mk_cfg(2, 1, 0, 2)));
      chk("R2 cfg load", 32'(cfg_o), 32'(mk_cfg(2, 1, 0, 2)));
      chk("R2 burst_on", 32'(burst_on), 1);
      chk("R9 array open after cfg", 32'(arr_sel), 1);
      do_burst(18'h00045, 2, 6, 1'b1, 3'd2, 1'b0, 1'b1, 1'b0);
      chk("R11 aps after read", 32'(aps), 1);
      chk("R9 register mode after first burst", 32'(arr_sel), 0);
      wr_cmd(8'hFF, '0);
      chk("R11 aps cleared on access", 32'(aps), 0);
      chk("R9 read array restores", 32'(arr_sel), 1);
      // R10
      set_cfg(BAW'(mk_cfg(1, 1, 0, 1)));
      wr_cmd(8'h70, '0);
      chk("R10 status mode", 32'(arr_sel), 0);
      do_burst(18'h00100, 1, 5, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0);
      // R7/R8 sweep
      foreach (bls[b]) begin
         for (int bw = 0; bw < 2; bw++) begin
            foreach (sts[si]) begin
               set_cfg(BAW'(mk_cfg(idx % 4, 1, bw[0], bls[b])));
               wr_cmd(8'hFF, '0);
               do_burst(sts[si], idx % 4, 20, 1'b1, bls[b], bw[0], 1'b1, 1'b0);
               idx++;
            end
         end
      end
      // R6 all latency codes
      for (int lc = 0; lc < 8; lc++) begin
         set_cfg(BAW'(mk_cfg(lc, 1, 0, 1)));
         wr_cmd(8'hFF, '0);
         do_burst(18'h00206, lc, 3, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0);
      end
      // R5 adv held low across two edges
      set_cfg(BAW'(mk_cfg(3, 1, 1, 7)));
      wr_cmd(8'hFF, '0);
      do_burst(18'h00300, 3, 4, 1'b1, 3'd7, 1'b1, 1'b1, 1'b1);
      // R12 low-active wait
      set_cfg(BAW'(mk_cfg(3, 0, 0, 3)));
      wr_cmd(8'hFF, '0);
      chk("R12 idle level low polarity", 32'(wait_o), 1);
      do_burst(18'h0001E, 3, 4, 1'b0, 3'd3, 1'b0, 1'b1, 1'b0);
      // R4 back in async mode
      set_cfg(18'h08000);
      chk("R2 async select", 32'(burst_on), 0);
      addr = 18'h0777F; #1;
      chk("R4 async after cfg", 32'(mem_addr), 32'h0777F);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule